// File: doc/BRIEF.md
# Mesh Router Node with Column-First Routing

This block is one node of a two-dimensional mesh whose rows and columns each form a half ring. A local agent hands it messages through an inject port. The node passes through traffic along its column and its row, and it ejects the messages addressed to itself through a local eject port. Every message carries a destination row, a destination column and a payload. A message travels along the column (Y) until it reaches its destination row. It then turns onto the row (X) and travels to its destination column. Hops never wrap around the edge of the mesh.

There are five one-entry input slots: north, south, east, west and local. Each slot is a two-state machine. In `SLOT_EMPTY` it raises ready, and a valid input moves it to `SLOT_HELD`. In `SLOT_HELD` it keeps ready low, and it returns to `SLOT_EMPTY` when its output accepts the message. Arbitration happens in only two places: when a message is injected and when a message turns from the column onto the row. Traffic that runs straight through always wins its output.

Each link output has an arbiter with a two-state preference machine, `FAVOR_TURN` or `FAVOR_INJECT`. When a turning message and an injected message compete for the same output and one of them is sent, the preference moves to the loser. Reset leaves the preference at `FAVOR_TURN`.

The mesh size and the node's own coordinates are parameters. The default is a 6x6 mesh with the node at column 2, row 2.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and just after it, every output valid is low and every input ready is high.
- R2: A message is laid out as {dest_y, dest_x, payload}, with dest_y in the top YW bits, dest_x in the next XW bits and the payload in the low PAYLOAD_W bits. A message whose dest_x and dest_y both equal the node's coordinates leaves on the eject port and never on a link.
- R3: When dest_y differs from the node's row, the message leaves north if dest_y is smaller and south if dest_y is larger, whatever its dest_x.
- R4: When dest_y equals the node's row, the message leaves east if dest_x is larger and west if dest_x is smaller. Turning traffic from the north and south slots is routed this way, and so is injected traffic.
- R5: Straight traffic continues unchanged. North-slot traffic goes out south, south-slot traffic goes out north, west-slot traffic goes out east and east-slot traffic goes out west.
- R6: A straight-through message is always granted its output ahead of a turning message or an injected message that wants the same output.
- R7: When a turning message and an injected message compete for an X output, the grant alternates between them. After reset the turning message is favoured.
- R8: A slot holding a message keeps its input ready low and its stored message unchanged until the message is sent.
- R9: A message accepted at a clock edge is presented at its output in the same cycle. The output valid stays high until the downstream ready is high.
- R10: When several messages want the eject port at once, the order of priority is west slot, east slot, north slot, south slot, local slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | Local inject valid |
| inj_ready | output | 1 | Local inject slot empty |
| inj_msg | input | MW | Local inject message |
| ej_valid | output | 1 | Eject valid |
| ej_ready | input | 1 | Local agent accepts ejected message |
| ej_msg | output | MW | Ejected message |
| n_in_valid | input | 1 | Valid from the northern neighbour (traffic heading south) |
| n_in_ready | output | 1 | North input slot empty |
| n_in_msg | input | MW | Message from the north |
| n_out_valid | output | 1 | Valid toward the northern neighbour |
| n_out_ready | input | 1 | Northern neighbour accepts |
| n_out_msg | output | MW | Message toward the north |
| s_in_valid | input | 1 | Valid from the southern neighbour (traffic heading north) |
| s_in_ready | output | 1 | South input slot empty |
| s_in_msg | input | MW | Message from the south |
| s_out_valid | output | 1 | Valid toward the southern neighbour |
| s_out_ready | input | 1 | Southern neighbour accepts |
| s_out_msg | output | MW | Message toward the south |
| e_in_valid | input | 1 | Valid from the eastern neighbour (traffic heading west) |
| e_in_ready | output | 1 | East input slot empty |
| e_in_msg | input | MW | Message from the east |
| e_out_valid | output | 1 | Valid toward the eastern neighbour |
| e_out_ready | input | 1 | Eastern neighbour accepts |
| e_out_msg | output | MW | Message toward the east |
| w_in_valid | input | 1 | Valid from the western neighbour (traffic heading east) |
| w_in_ready | output | 1 | West input slot empty |
| w_in_msg | input | MW | Message from the west |
| w_out_valid | output | 1 | Valid toward the western neighbour |
| w_out_ready | input | 1 | Western neighbour accepts |
| w_out_msg | output | MW | Message toward the west |

## Verification
The assertions assume that each link input carries only traffic a legal upstream node could send. Traffic from the north must have dest_y at or below the node's row, traffic from the south must have dest_y at or above it, and traffic on the east or west link must already be in the node's row and moving toward its column. Under those conditions no straight slot asks for a link it could not use, and the output checks on direction hold. The stimulus builds every message from these rules: each vector pairs an input port with coordinates that a neighbour could legally forward. Contention tests stall a single output ready, so arbitration is observed without any illegal route.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

    typedef enum logic [2:0] {
        PORT_N = 3'd0,
        PORT_S = 3'd1,
        PORT_E = 3'd2,
        PORT_W = 3'd3,
        PORT_L = 3'd4
    } port_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic {
        FAVOR_TURN   = 1'b0,
        FAVOR_INJECT = 1'b1
    } favor_e;

endpackage

// File: rtl/mesh_slot.sv
module mesh_slot
    import mesh_router_pkg::*;
#(
    parameter int XW = 3,
    parameter int YW = 3,
    parameter int PW = 8,
    parameter int X_POS = 0,
    parameter int Y_POS = 0,
    localparam int MW = YW + XW + PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [MW-1:0] in_msg,
    input  logic          deq,
    output logic          held,
    output logic [MW-1:0] msg,
    output port_e         route
);

    localparam logic [XW-1:0] MY_X = XW'(X_POS);
    localparam logic [YW-1:0] MY_Y = YW'(Y_POS);

    slot_state_e   state_q, state_d;
    logic [MW-1:0] msg_q;
    logic [YW-1:0] dst_y;
    logic [XW-1:0] dst_x;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (in_valid) state_d = SLOT_HELD;
            SLOT_HELD:  if (deq)      state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            msg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_EMPTY && in_valid) msg_q <= in_msg;
        end
    end

    always_comb begin
        in_ready = (state_q == SLOT_EMPTY);
        held     = (state_q == SLOT_HELD);
        msg      = msg_q;
        dst_y    = msg_q[MW-1 -: YW];
        dst_x    = msg_q[PW +: XW];
        if (dst_y < MY_Y)      route = PORT_N;
        else if (dst_y > MY_Y) route = PORT_S;
        else if (dst_x > MY_X) route = PORT_E;
        else if (dst_x < MY_X) route = PORT_W;
        else                   route = PORT_L;
    end

    assert_hold_until_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !deq) |=> (held && $stable(msg)));

    assert_deq_only_when_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> held);

endmodule

// File: rtl/mesh_xarb.sv
module mesh_xarb
    import mesh_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic straight_req,
    input  logic turn_req,
    input  logic inj_req,
    input  logic out_ready,
    output logic gnt_straight,
    output logic gnt_turn,
    output logic gnt_inj
);

    favor_e favor_q, favor_d;
    logic   contest;

    assign contest = turn_req && inj_req && !straight_req;

    always_comb begin
        favor_d = favor_q;
        unique case (favor_q)
            FAVOR_TURN:   if (contest && out_ready) favor_d = FAVOR_INJECT;
            FAVOR_INJECT: if (contest && out_ready) favor_d = FAVOR_TURN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) favor_q <= FAVOR_TURN;
        else        favor_q <= favor_d;
    end

    always_comb begin
        gnt_straight = straight_req;
        gnt_turn     = 1'b0;
        gnt_inj      = 1'b0;
        if (!straight_req) begin
            unique case (favor_q)
                FAVOR_TURN: begin
                    gnt_turn = turn_req;
                    gnt_inj  = inj_req && !turn_req;
                end
                FAVOR_INJECT: begin
                    gnt_inj  = inj_req;
                    gnt_turn = turn_req && !inj_req;
                end
            endcase
        end
    end

    assert_straight_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        straight_req |-> (!gnt_turn && !gnt_inj));

    assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (contest && gnt_turn && out_ready) |=> (!(turn_req && inj_req && !straight_req) || gnt_inj));

    assert_alternate_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (contest && gnt_inj && out_ready) |=> (!(turn_req && inj_req && !straight_req) || gnt_turn));

endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int MESH_X    = 6,
    parameter int MESH_Y    = 6,
    parameter int X_POS     = 2,
    parameter int Y_POS     = 2,
    parameter int PAYLOAD_W = 8,
    localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
    localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
    localparam int MW = YW + XW + PAYLOAD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inj_valid,
    output logic          inj_ready,
    input  logic [MW-1:0] inj_msg,
    output logic          ej_valid,
    input  logic          ej_ready,
    output logic [MW-1:0] ej_msg,
    input  logic          n_in_valid,
    output logic          n_in_ready,
    input  logic [MW-1:0] n_in_msg,
    output logic          n_out_valid,
    input  logic          n_out_ready,
    output logic [MW-1:0] n_out_msg,
    input  logic          s_in_valid,
    output logic          s_in_ready,
    input  logic [MW-1:0] s_in_msg,
    output logic          s_out_valid,
    input  logic          s_out_ready,
    output logic [MW-1:0] s_out_msg,
    input  logic          e_in_valid,
    output logic          e_in_ready,
    input  logic [MW-1:0] e_in_msg,
    output logic          e_out_valid,
    input  logic          e_out_ready,
    output logic [MW-1:0] e_out_msg,
    input  logic          w_in_valid,
    output logic          w_in_ready,
    input  logic [MW-1:0] w_in_msg,
    output logic          w_out_valid,
    input  logic          w_out_ready,
    output logic [MW-1:0] w_out_msg
);

    localparam int NSLOT = 5;
    localparam int NLINK = 4;
    localparam logic [XW-1:0] MY_X = XW'(X_POS);
    localparam logic [YW-1:0] MY_Y = YW'(Y_POS);

    // slot index: 0 north, 1 south, 2 east, 3 west, 4 local
    logic [NSLOT-1:0] in_v, in_r, held, deq;
    logic [MW-1:0]    in_m  [NSLOT];
    logic [MW-1:0]    sm    [NSLOT];
    port_e            route [NSLOT];

    // link index: 0 north, 1 south, 2 east, 3 west
    logic [NLINK-1:0] out_v, out_r;
    logic [MW-1:0]    out_m    [NLINK];
    logic [NSLOT-1:0] link_gnt [NLINK];
    logic [NSLOT-1:0] ej_gnt;

    assign in_v = {inj_valid, w_in_valid, e_in_valid, s_in_valid, n_in_valid};
    assign in_m[0] = n_in_msg;
    assign in_m[1] = s_in_msg;
    assign in_m[2] = e_in_msg;
    assign in_m[3] = w_in_msg;
    assign in_m[4] = inj_msg;
    assign {inj_ready, w_in_ready, e_in_ready, s_in_ready, n_in_ready} = in_r;

    assign out_r = {w_out_ready, e_out_ready, s_out_ready, n_out_ready};
    assign {w_out_valid, e_out_valid, s_out_valid, n_out_valid} = out_v;
    assign n_out_msg = out_m[0];
    assign s_out_msg = out_m[1];
    assign e_out_msg = out_m[2];
    assign w_out_msg = out_m[3];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        mesh_slot #(
            .XW(XW), .YW(YW), .PW(PAYLOAD_W), .X_POS(X_POS), .Y_POS(Y_POS)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .in_valid(in_v[s]), .in_ready(in_r[s]), .in_msg(in_m[s]),
            .deq(deq[s]), .held(held[s]), .msg(sm[s]), .route(route[s])
        );
    end

    for (genvar o = 0; o < NLINK; o++) begin : g_link
        localparam int    ST   = (o == 0) ? 1 : (o == 1) ? 0 : (o == 2) ? 3 : 2;
        localparam bit    IS_X = (o >= 2);
        localparam port_e OD   = port_e'(o);
        logic sreq, treq, ireq, tn, gs, gt, gi;
        logic [NSLOT-1:0] gv;

        assign sreq = held[ST] && (route[ST] == OD);
        assign tn   = held[0] && (route[0] == OD);
        assign treq = IS_X && (tn || (held[1] && (route[1] == OD)));
        assign ireq = held[4] && (route[4] == OD);

        mesh_xarb u_arb (
            .clk(clk), .rst_n(rst_n),
            .straight_req(sreq), .turn_req(treq), .inj_req(ireq),
            .out_ready(out_r[o]),
            .gnt_straight(gs), .gnt_turn(gt), .gnt_inj(gi)
        );

        always_comb begin
            gv     = '0;
            gv[ST] = gs;
            gv[0]  = gv[0] | (gt & tn);
            gv[1]  = gv[1] | (gt & ~tn);
            gv[4]  = gi;
        end

        assign link_gnt[o] = gv;
        assign out_v[o]    = gs | gt | gi;
        assign out_m[o]    = gs ? sm[ST] : (gt ? (tn ? sm[0] : sm[1]) : sm[4]);

        assert_no_self_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_v[o] |-> !((out_m[o][MW-1 -: YW] == MY_Y) && (out_m[o][PAYLOAD_W +: XW] == MY_X)));

        if (IS_X) begin : g_xchk
            assert_row_reached_R3: assert property (@(posedge clk) disable iff (!rst_n)
                out_v[o] |-> (out_m[o][MW-1 -: YW] == MY_Y));
        end

        assert_valid_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_v[o] && !out_r[o]) |=> out_v[o]);
    end

    always_comb begin
        ej_gnt = '0;
        if (held[3] && route[3] == PORT_L)      ej_gnt[3] = 1'b1;
        else if (held[2] && route[2] == PORT_L) ej_gnt[2] = 1'b1;
        else if (held[0] && route[0] == PORT_L) ej_gnt[0] = 1'b1;
        else if (held[1] && route[1] == PORT_L) ej_gnt[1] = 1'b1;
        else if (held[4] && route[4] == PORT_L) ej_gnt[4] = 1'b1;
    end

    assign ej_valid = |ej_gnt;
    always_comb begin
        ej_msg = sm[4];
        for (int s = 0; s < NSLOT; s++) if (ej_gnt[s]) ej_msg = sm[s];
    end

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            deq[s] = ej_gnt[s] & ej_ready;
            for (int o = 0; o < NLINK; o++) deq[s] = deq[s] | (link_gnt[o][s] & out_r[o]);
        end
    end

    assert_eject_is_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid |-> ((ej_msg[MW-1 -: YW] == MY_Y) && (ej_msg[PAYLOAD_W +: XW] == MY_X)));

    assert_eject_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_valid && !ej_ready) |=> ej_valid);

endmodule

// File: tb/mesh_router_test.sv
module mesh_router_test;

    localparam int MW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // index 0 N, 1 S, 2 E, 3 W, 4 local
    logic [4:0]    tin_v = '0;
    logic [MW-1:0] tin_m [5];
    logic [4:0]    tin_r;
    logic [4:0]    ov;
    logic [MW-1:0] om [5];
    logic [4:0]    ordy = '1;

    int n_chk = 0;
    int n_fail = 0;

    mesh_router uut (
        .clk(clk), .rst_n(rst_n),
        .inj_valid(tin_v[4]), .inj_ready(tin_r[4]), .inj_msg(tin_m[4]),
        .ej_valid(ov[4]), .ej_ready(ordy[4]), .ej_msg(om[4]),
        .n_in_valid(tin_v[0]), .n_in_ready(tin_r[0]), .n_in_msg(tin_m[0]),
        .n_out_valid(ov[0]), .n_out_ready(ordy[0]), .n_out_msg(om[0]),
        .s_in_valid(tin_v[1]), .s_in_ready(tin_r[1]), .s_in_msg(tin_m[1]),
        .s_out_valid(ov[1]), .s_out_ready(ordy[1]), .s_out_msg(om[1]),
        .e_in_valid(tin_v[2]), .e_in_ready(tin_r[2]), .e_in_msg(tin_m[2]),
        .e_out_valid(ov[2]), .e_out_ready(ordy[2]), .e_out_msg(om[2]),
        .w_in_valid(tin_v[3]), .w_in_ready(tin_r[3]), .w_in_msg(tin_m[3]),
        .w_out_valid(ov[3]), .w_out_ready(ordy[3]), .w_out_msg(om[3])
    );

    // {src, dest_y, dest_x, expected output}, node at x=2 y=2
    localparam logic [11:0] VEC [13] = '{
        {3'd4, 3'd0, 3'd5, 3'd0},   // R3 inject, row above -> N
        {3'd4, 3'd5, 3'd0, 3'd1},   // R3 inject, row below -> S
        {3'd4, 3'd2, 3'd5, 3'd2},   // R4 inject in row -> E
        {3'd4, 3'd2, 3'd0, 3'd3},   // R4 inject in row -> W
        {3'd4, 3'd2, 3'd2, 3'd4},   // R2 inject to self -> eject
        {3'd0, 3'd4, 3'd1, 3'd1},   // R5 north slot straight -> S
        {3'd0, 3'd2, 3'd4, 3'd2},   // R4 north slot turns -> E
        {3'd0, 3'd2, 3'd2, 3'd4},   // R2 north slot eject
        {3'd1, 3'd0, 3'd3, 3'd0},   // R5 south slot straight -> N
        {3'd1, 3'd2, 3'd0, 3'd3},   // R4 south slot turns -> W
        {3'd3, 3'd2, 3'd5, 3'd2},   // R5 west slot straight -> E
        {3'd2, 3'd2, 3'd0, 3'd3},   // R5 east slot straight -> W
        {3'd2, 3'd2, 3'd2, 3'd4}    // R2 east slot eject
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int idx);
        ordy[idx] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ordy[idx] = 1'b0;
    endtask

    function automatic logic [MW-1:0] mk(input int y, input int x, input int p);
        return {3'(y), 3'(x), 8'(p)};
    endfunction

    initial begin
        for (int i = 0; i < 5; i++) tin_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valids in reset", 32'(ov), 32'h0);
        chk("R1 readies in reset", 32'(tin_r), 32'h1f);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valids after reset", 32'(ov), 32'h0);
        chk("R1 readies after reset", 32'(tin_r), 32'h1f);

        // vector table, one message at a time, R9 same-cycle presentation
        for (int i = 0; i < 13; i++) begin
            int src;
            int ex;
            logic [MW-1:0] m;
            src = int'(VEC[i][11:9]);
            ex  = int'(VEC[i][2:0]);
            m   = {VEC[i][8:6], VEC[i][5:3], 8'(i)};
            tin_m[src] = m;
            tin_v[src] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tin_v[src] = 1'b0;
            chk("R2 R3 R4 R5 output select", 32'(ov), 32'(1 << ex));
            chk("R5 R9 message unchanged", 32'(om[ex]), 32'(m));
            chk("R8 slot ready low while held", 32'(tin_r[src]), 32'h0);
            @(posedge clk);
            @(negedge clk);
            chk("R9 drained", 32'(ov), 32'h0);
        end

        // R6: straight west->east beats injection to east
        ordy[2] = 1'b0;
        tin_m[3] = mk(2, 5, 8'hA1); tin_v[3] = 1'b1;
        tin_m[4] = mk(2, 5, 8'hA2); tin_v[4] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tin_v = '0;
        chk("R6 straight wins", 32'(om[2]), 32'(mk(2, 5, 8'hA1)));
        chk("R8 loser inject ready low", 32'(tin_r[4]), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 valid held while stalled", 32'(ov[2]), 32'h1);
        pulse(2);
        chk("R8 loser sent unchanged", 32'(om[2]), 32'(mk(2, 5, 8'hA2)));
        pulse(2);
        chk("R6 east idle after drain", 32'(ov[2]), 32'h0);

        // R7: turn vs inject alternation on east
        tin_m[0] = mk(2, 5, 8'hB1); tin_v[0] = 1'b1;
        tin_m[4] = mk(2, 5, 8'hB2); tin_v[4] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tin_v = '0;
        chk("R7 turn first after reset", 32'(om[2]), 32'(mk(2, 5, 8'hB1)));
        pulse(2);
        tin_m[0] = mk(2, 5, 8'hB3); tin_v[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tin_v = '0;
        chk("R7 inject next", 32'(om[2]), 32'(mk(2, 5, 8'hB2)));
        pulse(2);
        chk("R7 turn again", 32'(om[2]), 32'(mk(2, 5, 8'hB3)));
        pulse(2);
        ordy[2] = 1'b1;

        // R10: eject priority W, N, local
        ordy[4] = 1'b0;
        tin_m[3] = mk(2, 2, 8'hC1); tin_v[3] = 1'b1;
        tin_m[4] = mk(2, 2, 8'hC2); tin_v[4] = 1'b1;
        tin_m[0] = mk(2, 2, 8'hC3); tin_v[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tin_v = '0;
        chk("R10 west ejects first", 32'(om[4]), 32'(mk(2, 2, 8'hC1)));
        chk("R2 no link valid on eject", 32'(ov[3:0]), 32'h0);
        pulse(4);
        chk("R10 north before local", 32'(om[4]), 32'(mk(2, 2, 8'hC3)));
        pulse(4);
        chk("R10 local last", 32'(om[4]), 32'(mk(2, 2, 8'hC2)));
        pulse(4);
        ordy[4] = 1'b1;
        chk("R10 eject drained", 32'(ov), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule